// File: doc/BRIEF.md
# Serial Audio Word Receiver

This block receives a serial audio data stream and turns it into parallel words for a processor. Every serial input (data, bit-clock falling edges and frame syncs) reaches it as a single-cycle strobe or a level in the system clock domain. On each active bit-clock strobe the block takes one data bit into a shift register. It builds 8-bit or 16-bit words from these bits. Each finished word is written, together with the number of the slot it arrived in, into a 16-entry receive queue. The processor drains that queue through a simple read port.

A mode input picks which bit-clock and frame-sync pair drives reception. In synchronous mode the receiver uses the pair it shares with the transmit side. In asynchronous mode it uses its own dedicated pair. In normal framing, each frame carries one word. In network framing, a frame carries one to four back-to-back slots. Each slot has its own enable bit. A sticky overrun flag records words that were lost because the queue was full. A level interrupt request tells the processor that the queue has filled past a programmable mark.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `fifo_level` is 0, `irq` is 0, `overrun` is 0 and `rd_data`/`rd_slot` are 0.
- R2: A data bit is taken only on a cycle where the selected bit strobe is 1. A strobe that also sees the selected frame sync at 1 carries the first (most significant) bit of slot 0. Later bits shift in most significant bit first, so in 16-bit mode (`cfg_word16`=1) the word is the 16 bits in order of arrival.
- R3: In 8-bit mode (`cfg_word16`=0) a word completes after 8 bits. It is stored zero-extended, with the 8 bits in `rd_data[7:0]` and `rd_data[15:8]`=0.
- R4: With `cfg_async`=0 the shared pair (`sh_bclk_fall`, `sh_fsync`) drives reception. The dedicated pair has no effect.
- R5: With `cfg_async`=1 the dedicated pair (`rx_bclk_fall`, `rx_fsync`) drives reception. The shared pair has no effect.
- R6: In normal framing (`cfg_network`=0) exactly one word is taken per frame, tagged slot 0. Bit strobes after that word and before the next frame sync are ignored.
- R7: In network framing, slots 0 up to `cfg_slot_last` follow back to back without gaps after the frame sync. Each word is tagged with its slot index on `rd_slot`. After slot `cfg_slot_last` the block waits for the next frame sync.
- R8: A word that completes in slot s while `cfg_slot_en[s]`=0 is not stored. The slot count still advances.
- R9: The queue returns words in arrival order. A read strobe `rd_en` on a non-empty queue removes one entry, and `rd_data`/`rd_slot` show it from the next cycle on. A read on an empty queue changes nothing. `fifo_level` counts stored entries.
- R10: A word that completes while 16 entries are stored, with no read in the same cycle, is dropped and sets `overrun`. `overrun` stays set until `ovr_clr`. A word that completes in the same cycle as a read of a full queue is stored.
- R11: `irq` is 1 exactly when `fifo_level` in the previous cycle was at least `cfg_irq_level`.
- R12: A frame sync seen on a bit strobe in the middle of a word discards the partial word and restarts the frame at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_async | input | 1 | 1: dedicated receive pair, 0: shared pair |
| cfg_network | input | 1 | 1: multi-slot frames, 0: one word per frame |
| cfg_word16 | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfg_slot_last | input | 2 | Index of the last slot in a network frame |
| cfg_slot_en | input | 4 | Per-slot store enable |
| cfg_irq_level | input | 5 | Queue level at which `irq` is raised |
| sh_bclk_fall | input | 1 | Falling-edge strobe of the shared bit clock |
| sh_fsync | input | 1 | Shared frame sync level |
| rx_bclk_fall | input | 1 | Falling-edge strobe of the dedicated bit clock |
| rx_fsync | input | 1 | Dedicated frame sync level |
| ser_din | input | 1 | Serial receive data |
| rd_en | input | 1 | Read strobe: removes the oldest entry |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 16 | Data of the last entry read |
| rd_slot | output | 2 | Slot tag of the last entry read |
| fifo_level | output | 5 | Number of stored entries |
| irq | output | 1 | Queue at or above the threshold |
| overrun | output | 1 | Sticky flag: a word was dropped |

## Verification
Two events can land on the same clock edge: a word finishing on the serial side and a read of the queue on the processor side. The bench forces the hardest form of this collision. It first fills the queue to 16 entries, then places the read strobe on exactly the edge where the last bit of a further word is written. The result is judged at the ports: the popped entry must be the oldest one, the level must stay at 16, `overrun` must stay 0, and a full drain must then return the new word last. Separate directed cases cover a write into a full queue with no read, which must raise `overrun` and leave the contents unchanged.

// File: rtl/srx_pkg.sv
package srx_pkg;
  parameter int SLOT_W    = 2;
  parameter int MAX_SLOTS = 1 << SLOT_W;
  parameter int WORD_MAX  = 16;

  typedef enum logic {
    SRC_SHARED = 1'b0,
    SRC_OWN    = 1'b1
  } srx_src_e;
endpackage

// File: rtl/srx_src_sel.sv
module srx_src_sel
  import srx_pkg::*;
(
  input  logic     sel_async,
  input  logic     sh_stb,
  input  logic     sh_fs,
  input  logic     own_stb,
  input  logic     own_fs,
  output logic     bit_stb,
  output logic     frm_sync
);
  srx_src_e src;

  always_comb begin
    src = sel_async ? SRC_OWN : SRC_SHARED;
    case (src)
      SRC_OWN: begin
        bit_stb  = own_stb;
        frm_sync = own_fs;
      end
      default: begin
        bit_stb  = sh_stb;
        frm_sync = sh_fs;
      end
    endcase
  end
endmodule

// File: rtl/srx_framer.sv
module srx_framer #(
  parameter int WORD_MAX = 16,
  parameter int SLOT_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_stb,
  input  logic                   frm_sync,
  input  logic                   din,
  input  logic                   network,
  input  logic                   word16,
  input  logic [SLOT_W-1:0]      slot_last,
  input  logic [(1<<SLOT_W)-1:0] slot_en,
  output logic                   wr_valid,
  output logic [WORD_MAX-1:0]    wr_word,
  output logic [SLOT_W-1:0]      wr_slot
);
  localparam int CNT_W = $clog2(WORD_MAX + 1);
  localparam int HALF  = WORD_MAX / 2;
  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(WORD_MAX);
  localparam logic [CNT_W-1:0] LEN_HALF = CNT_W'(HALF);

  logic [WORD_MAX-1:0] shreg, sh_n;
  logic [CNT_W-1:0]    cnt, cnt_n, wlen;
  logic [SLOT_W-1:0]   slot, slot_n;
  logic                active;
  logic                start, take, done, last_slot;

  always_comb begin
    wlen  = word16 ? LEN_FULL : LEN_HALF;
    start = bit_stb && frm_sync;
    if (start) begin
      sh_n   = {{(WORD_MAX-1){1'b0}}, din};
      cnt_n  = CNT_W'(1);
      slot_n = '0;
    end else begin
      sh_n   = {shreg[WORD_MAX-2:0], din};
      cnt_n  = cnt + 1'b1;
      slot_n = slot;
    end
    take      = bit_stb && (start || active);
    done      = take && (cnt_n == wlen);
    last_slot = !network || (slot_n == slot_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      slot     <= '0;
      active   <= 1'b0;
      wr_valid <= 1'b0;
      wr_word  <= '0;
      wr_slot  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (take) begin
        shreg  <= sh_n;
        cnt    <= cnt_n;
        slot   <= slot_n;
        active <= 1'b1;
        if (done) begin
          cnt      <= '0;
          wr_valid <= slot_en[slot_n];
          wr_word  <= word16 ? sh_n : {{HALF{1'b0}}, sh_n[HALF-1:0]};
          wr_slot  <= slot_n;
          if (last_slot) active <= 1'b0;
          else           slot   <= slot_n + 1'b1;
        end
      end
    end
  end

  // R2: bit counter never passes the longest word
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LEN_FULL);
  // R7: a stored word never carries a slot past the configured last one
  a_r7_slot_bound: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !$past(rst)) |-> (wr_slot <= $past(slot_last)));
  // R6: normal framing tags every word slot 0
  a_r6_normal_slot0: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !$past(rst) && !$past(network)) |-> (wr_slot == '0));
  // R2: nothing is emitted without a bit strobe on the previous edge
  a_r2_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> !wr_valid);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       rd_en,
  input  logic                       ovr_clr,
  output logic [W-1:0]               rd_q,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       overrun
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0]  FULL_LVL = LVL_W'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  logic [W-1:0]      mem [DEPTH];
  logic [ADDR_W-1:0] wp, rp;
  logic              pop, full, accept;

  always_comb begin
    full   = (level == FULL_LVL);
    pop    = rd_en && (level != '0);
    accept = push && (!full || pop);
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (pop) begin
      rd_q <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (pop)    rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      case ({accept, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (push && !accept) overrun <= 1'b1;
      else if (ovr_clr)    overrun <= 1'b0;
    end
  end

  // R10: occupancy never exceeds the depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);
  // R10: a write into a full queue without a read raises the flag
  a_r10_drop_sets: assert property (@(posedge clk) disable iff (rst)
    (push && (level == FULL_LVL) && !rd_en) |=> overrun);
  // R10: the flag holds until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);
  // R9: an empty queue stays empty without a write
  a_r9_empty_hold: assert property (@(posedge clk) disable iff (rst)
    ((level == '0) && !push) |=> (level == '0));
  // R9: read data only changes after a read strobe
  a_r9_rd_stable: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(rd_q));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_async,
  input  logic                 cfg_network,
  input  logic                 cfg_word16,
  input  logic [SLOT_W-1:0]    cfg_slot_last,
  input  logic [MAX_SLOTS-1:0] cfg_slot_en,
  input  logic [LVL_W-1:0]     cfg_irq_level,
  input  logic                 sh_bclk_fall,
  input  logic                 sh_fsync,
  input  logic                 rx_bclk_fall,
  input  logic                 rx_fsync,
  input  logic                 ser_din,
  input  logic                 rd_en,
  input  logic                 ovr_clr,
  output logic [WORD_MAX-1:0]  rd_data,
  output logic [SLOT_W-1:0]    rd_slot,
  output logic [LVL_W-1:0]     fifo_level,
  output logic                 irq,
  output logic                 overrun
);
  localparam int ENTRY_W = WORD_MAX + SLOT_W;

  logic                bit_stb, frm_sync;
  logic                wr_valid;
  logic [WORD_MAX-1:0] wr_word;
  logic [SLOT_W-1:0]   wr_slot;
  logic [ENTRY_W-1:0]  rd_q;

  srx_src_sel u_sel (
    .sel_async (cfg_async),
    .sh_stb    (sh_bclk_fall),
    .sh_fs     (sh_fsync),
    .own_stb   (rx_bclk_fall),
    .own_fs    (rx_fsync),
    .bit_stb   (bit_stb),
    .frm_sync  (frm_sync)
  );

  srx_framer #(.WORD_MAX(WORD_MAX), .SLOT_W(SLOT_W)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .frm_sync  (frm_sync),
    .din       (ser_din),
    .network   (cfg_network),
    .word16    (cfg_word16),
    .slot_last (cfg_slot_last),
    .slot_en   (cfg_slot_en),
    .wr_valid  (wr_valid),
    .wr_word   (wr_word),
    .wr_slot   (wr_slot)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_valid),
    .push_data ({wr_slot, wr_word}),
    .rd_en     (rd_en),
    .ovr_clr   (ovr_clr),
    .rd_q      (rd_q),
    .level     (fifo_level),
    .overrun   (overrun)
  );

  assign rd_data = rd_q[WORD_MAX-1:0];
  assign rd_slot = rd_q[ENTRY_W-1:WORD_MAX];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (fifo_level >= cfg_irq_level);
  end

  // R11: request follows the previous cycle's level against the mark
  a_r11_irq_level: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == ($past(fifo_level) >= $past(cfg_irq_level))));
endmodule

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_async = 1'b0, cfg_network = 1'b0, cfg_word16 = 1'b1;
  logic [1:0]  cfg_slot_last = 2'd0;
  logic [3:0]  cfg_slot_en = 4'hF;
  logic [4:0]  cfg_irq_level = 5'd16;
  logic        sh_bclk_fall = 1'b0, sh_fsync = 1'b0;
  logic        rx_bclk_fall = 1'b0, rx_fsync = 1'b0;
  logic        ser_din = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [15:0] rd_data;
  logic [1:0]  rd_slot;
  logic [4:0]  fifo_level;
  logic        irq, overrun;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [17:0] mq [$];
  bit m_ovr = 1'b0;

  always #2 clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rst(rst), .cfg_async(cfg_async), .cfg_network(cfg_network),
    .cfg_word16(cfg_word16), .cfg_slot_last(cfg_slot_last), .cfg_slot_en(cfg_slot_en),
    .cfg_irq_level(cfg_irq_level), .sh_bclk_fall(sh_bclk_fall), .sh_fsync(sh_fsync),
    .rx_bclk_fall(rx_bclk_fall), .rx_fsync(rx_fsync), .ser_din(ser_din),
    .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_slot(rd_slot),
    .fifo_level(fifo_level), .irq(irq), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wlen();
    return cfg_word16 ? 16 : 8;
  endfunction

  task automatic m_push(input logic [1:0] s, input logic [15:0] v);
    logic [15:0] m;
    m = cfg_word16 ? v : {8'h00, v[7:0]};
    if (cfg_slot_en[s]) begin
      if (mq.size() < 16) mq.push_back({s, m});
      else m_ovr = 1'b1;
    end
  endtask

  // one bit on the selected pair, random noise on the other pair
  task automatic ser_bit(input logic b, input logic f, input bit pop_after);
    @(negedge clk);
    ser_din = b;
    if (cfg_async) begin
      rx_bclk_fall = 1'b1; rx_fsync = f;
      sh_bclk_fall = 1'($urandom % 2); sh_fsync = 1'($urandom % 2);
    end else begin
      sh_bclk_fall = 1'b1; sh_fsync = f;
      rx_bclk_fall = 1'($urandom % 2); rx_fsync = 1'($urandom % 2);
    end
    @(negedge clk);
    sh_bclk_fall = 1'b0; sh_fsync = 1'b0; rx_bclk_fall = 1'b0; rx_fsync = 1'b0;
    if (pop_after) rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ser_word(input logic [15:0] v, input int n, input bit fs_first, input bit pop_last);
    for (int i = n - 1; i >= 0; i--)
      ser_bit(v[i], fs_first && (i == n - 1), pop_last && (i == 0));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_normal(input logic [15:0] v, input int junk);
    ser_word(v, wlen(), 1'b1, 1'b0);
    m_push(2'd0, v);
    for (int j = 0; j < junk; j++) ser_bit(1'($urandom % 2), 1'b0, 1'b0);
  endtask

  task automatic frame_net();
    for (int s = 0; s <= int'(cfg_slot_last); s++) begin
      logic [15:0] v;
      v = 16'($urandom);
      ser_word(v, wlen(), s == 0, 1'b0);
      m_push(2'(s), v);
    end
  endtask

  task automatic drain(input string req);
    settle();
    check({req, " level"}, int'(fifo_level), mq.size());
    while (mq.size() > 0) begin
      logic [17:0] e;
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      e = mq.pop_front();
      check({req, " data"}, int'(rd_data), int'(e[15:0]));
      check({req, " slot"}, int'(rd_slot), int'(e[17:16]));
    end
    settle();
    check("R9 empty level", int'(fifo_level), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 level", int'(fifo_level), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 data", int'(rd_data), 0);

    // R2 R4 R6: shared pair, 16-bit, junk strobes after each word
    cfg_async = 1'b0; cfg_word16 = 1'b1; cfg_network = 1'b0;
    for (int k = 0; k < 6; k++) frame_normal(16'($urandom), 3);
    frame_normal(16'h8001, 2);
    drain("R2 R4 R6");

    // empty read has no effect (R9)
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    settle();
    check("R9 empty read level", int'(fifo_level), 0);
    check("R9 empty read data", int'(rd_data), 16'h8001);

    // R3 R5: dedicated pair, 8-bit words
    cfg_async = 1'b1; cfg_word16 = 1'b0;
    for (int k = 0; k < 6; k++) frame_normal(16'($urandom), 2);
    drain("R3 R5");

    // R7 R8: network frames with random slot count and enables
    cfg_network = 1'b1;
    for (int r = 0; r < 4; r++) begin
      cfg_async = 1'($urandom % 2);
      cfg_word16 = 1'($urandom % 2);
      cfg_slot_last = 2'($urandom);
      cfg_slot_en = 4'($urandom);
      for (int k = 0; k < 3; k++) frame_net();
      drain("R7 R8");
    end
    cfg_slot_last = 2'd3; cfg_slot_en = 4'b1010; cfg_word16 = 1'b1;
    frame_net();
    drain("R8 directed");

    // R12: frame sync in mid-word restarts framing
    cfg_network = 1'b0; cfg_slot_en = 4'hF; cfg_async = 1'b0;
    ser_word(16'h5A5A, 5, 1'b1, 1'b0);
    frame_normal(16'hC3E1, 0);
    drain("R12");

    // R11: threshold crossing
    cfg_irq_level = 5'd3;
    frame_normal(16'h1111, 0);
    frame_normal(16'h2222, 0);
    settle();
    check("R11 below", int'(irq), 0);
    frame_normal(16'h3333, 0);
    settle();
    check("R11 at mark", int'(irq), 1);
    drain("R11");
    check("R11 after drain", int'(irq), 0);

    // R10: fill, overflow, clear, simultaneous write and read
    cfg_irq_level = 5'd16;
    for (int k = 0; k < 16; k++) frame_normal(16'($urandom), 0);
    settle();
    check("R10 full level", int'(fifo_level), 16);
    check("R11 full irq", int'(irq), 1);
    check("R10 no overrun yet", int'(overrun), 0);
    frame_normal(16'hDEAD, 0);
    frame_normal(16'hBEEF, 0);
    settle();
    check("R10 overrun set", int'(overrun), int'(m_ovr));
    check("R10 level held", int'(fifo_level), 16);
    @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    settle();
    check("R10 overrun cleared", int'(overrun), 0);
    begin
      logic [17:0] e;
      ser_word(16'hA55A, 16, 1'b1, 1'b1);
      e = mq.pop_front();
      mq.push_back({2'd0, 16'hA55A});
      check("R10 pop on full", int'(rd_data), int'(e[15:0]));
    end
    settle();
    check("R10 level after collision", int'(fifo_level), 16);
    check("R10 no drop on collision", int'(overrun), 0);
    drain("R10");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule